// File: doc/BRIEF.md
# Equalization and serration inserter

This block produces the final composite sync level of a video timing generator, before output polarity is applied. Outside a programmed vertical window it merges the horizontal and vertical sync levels. Inside the window it replaces both with a train of narrow equalization pulses. Where vertical sync is active inside the window, it uses broad serration pulses instead. The pulses come either once per line or twice per line, at half the line length.

The block takes the horizontal clock count (1 to the line total) and the vertical count from an external counter. In interlaced mode the vertical count is in half-lines, and the block derives the odd/even field flag from it. All timing values are inputs from the configuration registers. The composite sync and field flag outputs are registered, with one cycle of latency. An error flag shows that the reserved mode code was selected.

Top module: `eqs_inserter`

## Requirements
- R1: `mode_i` selects the operating mode. 2'b00 is interlaced with two pulses per line. 2'b01 is non-interlaced with two pulses per line. 2'b11 is non-interlaced with one pulse per line. The reserved code 2'b10 behaves exactly like 2'b11.
- R2: `mode_err_o` is 1 in the cycle after `mode_i` was 2'b10, and 0 in all other cases.
- R3: In the two-pulse modes the pulse position is `h` when `h <= htotal_i/2`, and `h - htotal_i/2` otherwise (integer halving). In the one-pulse mode the position is `h`.
- R4: An equalization pulse is active when `hfp_i <= pos < eq_end_i`.
- R5: A serration pulse is active when `pos >= serr_start_i` or `pos < hfp_i`. Serration pulses replace the sync level wherever `vsync_i` is 1 inside the window.
- R6: The window holds when `win_start_i <= v < win_end_i`. Outside the window the output is `hsync_i | vsync_i`. Inside the window with `vsync_i` at 0, the output is the equalization pulse.
- R7: When `eq_dis_i` is 1, no pulses are inserted and the output is `hsync_i | vsync_i` everywhere.
- R8: When `csync_sel_i` is 0, the output is `vsync_i` alone and no pulses are inserted.
- R9: In interlaced mode, `odd_o` is 1 while `v <= vtotal_i` and 0 for larger half-line counts. In non-interlaced modes it is always 1.
- R10: The outputs follow their inputs one clock later. During reset `csync_o` is 0, `odd_o` is 1 and `mode_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| h_cnt_i | input | CW | horizontal count, starting at 1 |
| v_cnt_i | input | CW+1 | vertical count, in lines or half-lines |
| vtotal_i | input | CW | lines per frame |
| mode_i | input | 2 | operating mode code |
| eq_dis_i | input | 1 | 1 disables pulse insertion |
| csync_sel_i | input | 1 | composite sync selected |
| hsync_i | input | 1 | horizontal sync level, active high |
| vsync_i | input | 1 | vertical sync level, active high |
| hfp_i | input | CW | front porch end, start of the pulses |
| htotal_i | input | CW | clocks per line |
| eq_end_i | input | CW | end of the equalization pulse |
| serr_start_i | input | CW | start of the serration pulse |
| win_start_i | input | CW+1 | first vertical count of the window |
| win_end_i | input | CW+1 | vertical count that ends the window |
| csync_o | output | 1 | composite sync, active high |
| odd_o | output | 1 | odd field flag |
| mode_err_o | output | 1 | reserved mode selected |

## Verification
The assertions check on every cycle the cases that depend on a single control input. These are the error flag, the vertical-only output when composite is deselected, the merged output when insertion is disabled, and the constant odd flag in non-interlaced modes. The pulse shapes depend on how position, window and vertical sync combine. So only the bench's reference model shows them, over full frames in every mode, including the two-pulse folding at half the line and the field change at the middle of the frame.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  typedef enum logic [1:0] {
    MODE_IL_DBL = 2'b00,
    MODE_NI_DBL = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_NI_SGL = 2'b11
  } eqs_mode_e;
endpackage

// File: rtl/eqs_mode_dec.sv
module eqs_mode_dec
  import eqs_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       interlace_o,
  output logic       dbl_o,
  output logic       err_o
);
  // R1: reserved code falls back to single-rate non-interlaced
  always_comb begin
    interlace_o = 1'b0;
    dbl_o       = 1'b0;
    err_o       = 1'b0;
    unique case (eqs_mode_e'(mode_i))
      MODE_IL_DBL: begin interlace_o = 1'b1; dbl_o = 1'b1; end
      MODE_NI_DBL: dbl_o = 1'b1;
      MODE_RSVD:   err_o = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/eqs_pulse_gen.sv
module eqs_pulse_gen #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] h_cnt_i,
  input  logic          dbl_i,
  input  logic [CW-1:0] hfp_i,
  input  logic [CW-1:0] htotal_i,
  input  logic [CW-1:0] eq_end_i,
  input  logic [CW-1:0] serr_start_i,
  output logic          eq_o,
  output logic          serr_o
);
  logic [CW-1:0] half_len, pos;

  // R3: fold the line at half length for twice-per-line pulses
  assign half_len = dbl_i ? {1'b0, htotal_i[CW-1:1]} : htotal_i;
  assign pos      = (h_cnt_i > half_len) ? h_cnt_i - half_len : h_cnt_i;

  // R4, R5
  assign eq_o   = (pos >= hfp_i) && (pos < eq_end_i);
  assign serr_o = (pos >= serr_start_i) || (pos < hfp_i);
endmodule

// File: rtl/eqs_window.sv
module eqs_window #(
  parameter int CW = 12,
  localparam int VW = CW + 1
) (
  input  logic [VW-1:0] v_cnt_i,
  input  logic [CW-1:0] vtotal_i,
  input  logic          interlace_i,
  input  logic [VW-1:0] win_start_i,
  input  logic [VW-1:0] win_end_i,
  output logic          in_win_o,
  output logic          odd_o
);
  // R6
  assign in_win_o = (v_cnt_i >= win_start_i) && (v_cnt_i < win_end_i);
  // R9: first field spans half-lines 1..vtotal
  assign odd_o    = !interlace_i || (v_cnt_i <= {1'b0, vtotal_i});
endmodule

// File: rtl/eqs_inserter.sv
module eqs_inserter #(
  parameter int CW = 12,
  localparam int VW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] h_cnt_i,
  input  logic [VW-1:0] v_cnt_i,
  input  logic [CW-1:0] vtotal_i,
  input  logic [1:0]    mode_i,
  input  logic          eq_dis_i,
  input  logic          csync_sel_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic [CW-1:0] hfp_i,
  input  logic [CW-1:0] htotal_i,
  input  logic [CW-1:0] eq_end_i,
  input  logic [CW-1:0] serr_start_i,
  input  logic [VW-1:0] win_start_i,
  input  logic [VW-1:0] win_end_i,
  output logic          csync_o,
  output logic          odd_o,
  output logic          mode_err_o
);
  logic interlace, dbl, err, eq_p, serr_p, in_win, odd_d, cs_d;

  eqs_mode_dec u_dec (
    .mode_i(mode_i), .interlace_o(interlace), .dbl_o(dbl), .err_o(err)
  );

  eqs_pulse_gen #(.CW(CW)) u_pulse (
    .h_cnt_i(h_cnt_i), .dbl_i(dbl), .hfp_i(hfp_i), .htotal_i(htotal_i),
    .eq_end_i(eq_end_i), .serr_start_i(serr_start_i),
    .eq_o(eq_p), .serr_o(serr_p)
  );

  eqs_window #(.CW(CW)) u_win (
    .v_cnt_i(v_cnt_i), .vtotal_i(vtotal_i), .interlace_i(interlace),
    .win_start_i(win_start_i), .win_end_i(win_end_i),
    .in_win_o(in_win), .odd_o(odd_d)
  );

  always_comb begin
    if (!csync_sel_i)               cs_d = vsync_i;
    else if (in_win && !eq_dis_i)   cs_d = vsync_i ? serr_p : eq_p;
    else                            cs_d = hsync_i | vsync_i;
  end

  // R10
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csync_o    <= 1'b0;
      odd_o      <= 1'b1;
      mode_err_o <= 1'b0;
    end else begin
      csync_o    <= cs_d;
      odd_o      <= odd_d;
      mode_err_o <= err;
    end
  end

  // R2
  mode_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |=> mode_err_o);
  // R2
  mode_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10) |=> !mode_err_o);
  // R8
  vsync_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csync_sel_i |=> (csync_o == $past(vsync_i)));
  // R7
  no_insert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csync_sel_i && eq_dis_i) |=> (csync_o == $past(hsync_i | vsync_i)));
  // R9
  odd_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00) |=> odd_o);
endmodule

// File: tb/eqs_inserter_bench.sv
`timescale 1ns/1ps
module eqs_inserter_bench;
  localparam int CW = 12;
  localparam int VW = CW + 1;
  localparam int HT = 40, HFP = 3, HS_END = 8, EQ_END = 7, SERR_ST = 15;
  localparam int VT = 10;

  logic clk = 0, rst_ni = 0;
  logic [CW-1:0] h_cnt = 1, vtotal = VT[CW-1:0];
  logic [VW-1:0] v_cnt = 1, win_s = 0, win_e = 0;
  logic [1:0] mode = 0;
  logic eq_dis = 0, cs_sel = 1, hs = 0, vs = 0;
  logic csync, odd, merr;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eqs_inserter #(.CW(CW)) u_eqs_inserter (
    .clk_i(clk), .rst_ni(rst_ni), .h_cnt_i(h_cnt), .v_cnt_i(v_cnt),
    .vtotal_i(vtotal), .mode_i(mode), .eq_dis_i(eq_dis), .csync_sel_i(cs_sel),
    .hsync_i(hs), .vsync_i(vs), .hfp_i(HFP[CW-1:0]), .htotal_i(HT[CW-1:0]),
    .eq_end_i(EQ_END[CW-1:0]), .serr_start_i(SERR_ST[CW-1:0]),
    .win_start_i(win_s), .win_end_i(win_e),
    .csync_o(csync), .odd_o(odd), .mode_err_o(merr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d h=%0d v=%0d mode=%0d act=%0b exp=%0b",
               req, cyc, h_cnt, v_cnt, mode, act, exp);
    end
  endtask

  // behavioural reference for the current inputs; returns tag of governing rule
  function automatic logic ref_cs(output string tag);
    int span, p;
    bit win;
    span = (mode == 2'b00 || mode == 2'b01) ? HT / 2 : HT;
    p = ((int'(h_cnt) - 1) % span) + 1;
    win = int'(v_cnt) >= int'(win_s) && int'(v_cnt) < int'(win_e);
    if (!cs_sel) begin tag = "R8"; return vs; end
    if (eq_dis) begin tag = "R7"; return hs | vs; end
    if (!win) begin tag = "R6"; return hs | vs; end
    if (vs) begin tag = "R5"; return (p >= SERR_ST) || (p < HFP); end
    tag = (span == HT) ? "R4" : "R3";
    return (p >= HFP) && (p < EQ_END);
  endfunction

  // run whole frames; vertical unit is half-lines when interlaced
  task automatic run(input logic [1:0] m, input bit dis, input bit sel, input int frames);
    bit il;
    int vmax, units;
    string tag;
    logic e;
    il = (m == 2'b00);
    @(negedge clk);
    mode = m; eq_dis = dis; cs_sel = sel;
    vmax  = il ? 2 * VT : VT;
    win_s = il ? VW'(5) : VW'(2);
    win_e = il ? VW'(16) : VW'(7);
    for (int f = 0; f < frames; f++)
      for (int v = 1; v <= vmax; v++)
        for (int h = 1; h <= HT; h++) begin
          v_cnt = VW'(v); h_cnt = CW'(h);
          hs = (h >= HFP) && (h < HS_END);
          vs = il ? (v >= 7 && v < 13) : (v >= 3 && v < 5);
          e = ref_cs(tag);
          @(negedge clk);
          cyc++;
          // R10: result of inputs held over the last edge
          chk(tag, csync, e);
          chk("R9", odd, il ? (v <= VT) : 1'b1);
          chk(m == 2'b10 ? "R2" : "R1", merr, m == 2'b10);
        end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", csync, 1'b0);
    chk("R10", odd, 1'b1);
    chk("R10", merr, 1'b0);
    rst_ni = 1;
    run(2'b00, 0, 1, 2);
    run(2'b01, 0, 1, 1);
    run(2'b11, 0, 1, 1);
    run(2'b10, 0, 1, 1);
    run(2'b01, 1, 1, 1);
    run(2'b00, 0, 0, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule